// File: doc/BRIEF.md
# Page-Mode Burst Read Sequencer for Pseudo-SRAM

This block turns one host request into a short burst of reads from an asynchronous pseudo-SRAM whose array is organised in four-word pages. The host supplies a word address and a word count from 1 to 4. The burst must fit inside one aligned page. When the request is accepted, the sequencer drives chip enable, output enable and every byte-lane enable active together and holds the page part of the address constant. It waits a full random-access interval before it samples the first word. After that it advances only the in-page offset bits, and each later word waits the shorter in-page interval.

Each sampled word goes back to the host with a one-cycle valid strobe and a tag that carries its in-page offset. The last word of the burst is also marked. After that word the device is deselected for a guaranteed recovery time before the sequencer accepts another request. A request that is malformed, or that would run past the end of its page, is refused with a one-cycle error pulse and no access. All timing intervals are given in nanoseconds as parameters and rounded up to whole clock cycles. An elaboration check makes sure that the longest burst fits inside the device's self-refresh window.

Top module: `psr_page_reader`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n, mem_we_n and every mem_be_n bit are 1, rsp_valid and req_err are 0, and req_ready is 1.
- R2: A request with req_words in 1..4 and (req_addr[1:0] + req_words) <= 4 is accepted at a clock edge where req_ready is 1. From the next cycle until the edge that samples the final word, mem_ce_n, mem_oe_n and all mem_be_n bits are 0. mem_we_n stays 1 at all times.
- R3: While mem_ce_n stays 0, mem_addr[22:2] keeps the value of req_addr[22:2], and only mem_addr[1:0] changes.
- R4: The first word is sampled FIRST_CYC = ceil(70 ns / clock period) cycles after acceptance, which is 7 cycles at 100 MHz. rsp_valid is high in the cycle that follows that edge.
- R5: Each later word is sampled PAGE_CYC = ceil(max(25, 20) ns / clock period) cycles after the previous one, which is 3 cycles at 100 MHz.
- R6: Words come back in increasing offset order starting at req_addr[1:0]. rsp_tag equals mem_addr[1:0] of the word, and rsp_data equals mem_rdata at that address.
- R7: Exactly req_words responses are produced, and rsp_last is 1 on the final one only.
- R8: A request with req_words = 0, req_words > 4, or (req_addr[1:0] + req_words) > 4 produces req_err = 1 for exactly one cycle, no rsp_valid, and no low pulse on mem_ce_n.
- R9: After the final word, mem_ce_n stays 1 for at least RECOV_CYC + 1 cycles before it falls again, where RECOV_CYC = ceil(10 ns / clock period). At defaults this is at least 2 cycles.
- R10: req_ready is 0 for as long as mem_ce_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 23 | Word address of the first word |
| req_words | input | 3 | Number of words, 1 to 4 |
| req_err | output | 1 | One-cycle pulse: request refused |
| rsp_valid | output | 1 | Response word strobe |
| rsp_data | output | 16 | Response word |
| rsp_tag | output | 2 | In-page offset of the response word |
| rsp_last | output | 1 | Final word of the burst |
| mem_addr | output | 23 | Device address |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, held high |
| mem_be_n | output | 2 | Device byte-lane enables, active low |
| mem_rdata | input | 16 | Device read data |

## Verification
Four properties are checked in every cycle: the page bits of the address hold steady while the device is selected, the first sample lands exactly FIRST_CYC cycles after acceptance, each step advances the offset by one, and the device is released after the final word. Every cycle also checks that a refused request leaves the device deselected and that the host is never offered a request slot while the device is selected. Data correctness, the in-page spacing of later words, response ordering, the response count and the minimum deselect gap can only be shown by the bench scenarios. For this, the bench uses a device model that returns a poison value whenever the access time it has seen is too short.

// File: rtl/psr_pkg.sv
package psr_pkg;

   typedef enum logic [1:0] {
      PS_IDLE  = 2'd0,
      PS_FIRST = 2'd1,
      PS_PAGE  = 2'd2,
      PS_REST  = 2'd3
   } psr_state_e;

   // Round a nanosecond interval up to whole clock cycles.
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psr_req_gate.sv
module psr_req_gate #(
   parameter int unsigned PAGE_WORDS = 4,
   parameter int unsigned OFF_W      = 2,
   parameter int unsigned CNT_W      = 3
) (
   input  logic [OFF_W-1:0] start_off,
   input  logic [CNT_W-1:0] words,
   output logic             fits
);

   localparam int unsigned SUM_W = ((OFF_W > CNT_W) ? OFF_W : CNT_W) + 1;

   logic [SUM_W-1:0] end_pos;

   initial begin
      assert (PAGE_WORDS == (1 << OFF_W))
         else $error("psr_req_gate: PAGE_WORDS must equal 2**OFF_W");
      assert ((1 << CNT_W) > PAGE_WORDS)
         else $error("psr_req_gate: CNT_W too narrow to encode a full page");
   end

   always_comb begin
      end_pos = SUM_W'(start_off) + SUM_W'(words);
      fits    = (words != '0)
             && (SUM_W'(words) <= SUM_W'(PAGE_WORDS))
             && (end_pos <= SUM_W'(PAGE_WORDS));
   end

endmodule

// File: rtl/psr_wait_timer.sv
module psr_wait_timer #(
   parameter int unsigned TW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expire
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = (cnt_q == TW'(1));

   AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0)); // R4

endmodule

// File: rtl/psr_addr_stepper.sv
module psr_addr_stepper #(
   parameter int unsigned ADDR_W = 23,
   parameter int unsigned OFF_W  = 2,
   parameter int unsigned CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  start_words,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic [OFF_W-1:0]  off,
   output logic              is_last
);

   localparam int unsigned PG_W = ADDR_W - OFF_W;

   logic [PG_W-1:0]  page_q;
   logic [OFF_W-1:0] off_q;
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         off_q  <= '0;
         left_q <= '0;
      end else if (start) begin
         page_q <= start_addr[ADDR_W-1:OFF_W];
         off_q  <= start_addr[OFF_W-1:0];
         left_q <= start_words - 1'b1;
      end else if (step) begin
         off_q  <= off_q + 1'b1;
         left_q <= left_q - 1'b1;
      end
   end

   assign addr    = {page_q, off_q};
   assign off     = off_q;
   assign is_last = (left_q == '0);

   AST_STEP_NEXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start) |=> (off_q == $past(off_q) + 1'b1)); // R6
   AST_STEP_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !start) |=> (page_q == $past(page_q))); // R3

endmodule

// File: rtl/psr_page_reader.sv
module psr_page_reader #(
   parameter int unsigned ADDR_W     = 23,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned PAGE_WORDS = 4,
   parameter int unsigned CNT_W      = 3,
   parameter int unsigned CLK_NS     = 10,
   parameter int unsigned T_AA_NS    = 70,
   parameter int unsigned T_PC_NS    = 25,
   parameter int unsigned T_PA_NS    = 20,
   parameter int unsigned T_CSH_NS   = 10,
   parameter int unsigned T_REFR_NS  = 1200
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [CNT_W-1:0]              req_words,
   output logic                          req_err,
   output logic                          rsp_valid,
   output logic [DATA_W-1:0]             rsp_data,
   output logic [$clog2(PAGE_WORDS)-1:0] rsp_tag,
   output logic                          rsp_last,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic                          mem_ce_n,
   output logic                          mem_oe_n,
   output logic                          mem_we_n,
   output logic [DATA_W/8-1:0]           mem_be_n,
   input  logic [DATA_W-1:0]             mem_rdata
);

   import psr_pkg::*;

   localparam int unsigned OFF_W     = $clog2(PAGE_WORDS);
   localparam int unsigned LANES     = DATA_W / 8;
   localparam int unsigned FIRST_CYC = ns_to_cyc(T_AA_NS, CLK_NS);
   localparam int unsigned PAGE_CYC  = ns_to_cyc(max2(T_PC_NS, T_PA_NS), CLK_NS);
   localparam int unsigned RECOV_CYC = max2(ns_to_cyc(T_CSH_NS, CLK_NS), 1);
   localparam int unsigned MAX_CYC   = max2(FIRST_CYC, max2(PAGE_CYC, RECOV_CYC));
   localparam int unsigned TW        = $clog2(MAX_CYC + 1);
   localparam int unsigned BURST_NS  = (FIRST_CYC + (PAGE_WORDS - 1) * PAGE_CYC) * CLK_NS;

   initial begin
      assert (OFF_W >= 1 && ADDR_W > OFF_W)
         else $error("psr_page_reader: address must be wider than the page offset");
      assert (DATA_W % 8 == 0 && LANES >= 1)
         else $error("psr_page_reader: DATA_W must be a whole number of bytes");
      assert (FIRST_CYC >= 1 && PAGE_CYC >= 1)
         else $error("psr_page_reader: access intervals must be at least one cycle");
      assert (BURST_NS <= T_REFR_NS)
         else $error("psr_page_reader: longest burst exceeds the self-refresh window");
   end

   psr_state_e        state_q;
   logic              ce_n_q, oe_n_q, lane_n_q;
   logic              accept, reject, fits;
   logic              tmr_load, tmr_expire, step;
   logic [TW-1:0]     tmr_val;
   logic [OFF_W-1:0]  cur_off;
   logic              cur_last;

   psr_req_gate #(
      .PAGE_WORDS (PAGE_WORDS),
      .OFF_W      (OFF_W),
      .CNT_W      (CNT_W)
   ) u_gate (
      .start_off (req_addr[OFF_W-1:0]),
      .words     (req_words),
      .fits      (fits)
   );

   assign req_ready = (state_q == PS_IDLE);
   assign accept    = req_ready && req_valid && fits;
   assign reject    = req_ready && req_valid && !fits;

   psr_addr_stepper #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .CNT_W  (CNT_W)
   ) u_step (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_addr  (req_addr),
      .start_words (req_words),
      .step        (step),
      .addr        (mem_addr),
      .off         (cur_off),
      .is_last     (cur_last)
   );

   psr_wait_timer #(
      .TW (TW)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      step     = 1'b0;
      unique case (state_q)
         PS_IDLE: begin
            if (accept) begin
               tmr_load = 1'b1;
               tmr_val  = TW'(FIRST_CYC);
            end
         end
         PS_FIRST, PS_PAGE: begin
            if (tmr_expire) begin
               tmr_load = 1'b1;
               if (cur_last) begin
                  tmr_val = TW'(RECOV_CYC);
               end else begin
                  tmr_val = TW'(PAGE_CYC);
                  step    = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= PS_IDLE;
         ce_n_q    <= 1'b1;
         oe_n_q    <= 1'b1;
         lane_n_q  <= 1'b1;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_tag   <= '0;
         rsp_last  <= 1'b0;
         req_err   <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         req_err   <= reject;
         unique case (state_q)
            PS_IDLE: begin
               if (accept) begin
                  state_q  <= PS_FIRST;
                  ce_n_q   <= 1'b0;
                  oe_n_q   <= 1'b0;
                  lane_n_q <= 1'b0;
               end
            end
            PS_FIRST, PS_PAGE: begin
               if (tmr_expire) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= mem_rdata;
                  rsp_tag   <= cur_off;
                  rsp_last  <= cur_last;
                  if (cur_last) begin
                     state_q  <= PS_REST;
                     ce_n_q   <= 1'b1;
                     oe_n_q   <= 1'b1;
                     lane_n_q <= 1'b1;
                  end else begin
                     state_q  <= PS_PAGE;
                  end
               end
            end
            PS_REST: begin
               if (tmr_expire) state_q <= PS_IDLE;
            end
            default: state_q <= PS_IDLE;
         endcase
      end
   end

   assign mem_ce_n = ce_n_q;
   assign mem_oe_n = oe_n_q;
   assign mem_we_n = 1'b1;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign mem_be_n[b] = lane_n_q;
   end

   // Independent age counter for the first-word latency property.
   logic [TW-1:0] first_age_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_age_q <= '0;
      end else if (accept) begin
         first_age_q <= TW'(1);
      end else if (first_age_q != '1) begin
         first_age_q <= first_age_q + 1'b1;
      end
   end

   AST_PAGE_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]))); // R3
   AST_FIRST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_FIRST && tmr_expire) |-> (first_age_q == TW'(FIRST_CYC))); // R4
   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (mem_ce_n && !rsp_valid)); // R8
   AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_last) |=> mem_ce_n); // R9
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready); // R10

endmodule

// File: tb/psr_page_reader_tb.sv
module psr_page_reader_tb;

   localparam int FIRST = 7;   // ceil(70/10)
   localparam int PAGE  = 3;   // ceil(25/10)
   localparam logic [15:0] POISON = 16'hDEAD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [22:0] req_addr = '0;
   logic [2:0]  req_words = '0;
   logic        req_err;
   logic        rsp_valid;
   logic [15:0] rsp_data;
   logic [1:0]  rsp_tag;
   logic        rsp_last;
   logic [22:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n;
   logic [1:0]  mem_be_n;
   logic [15:0] mem_rdata;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   psr_page_reader u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready),
      .req_addr (req_addr), .req_words (req_words), .req_err (req_err),
      .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_tag (rsp_tag), .rsp_last (rsp_last),
      .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
      .mem_we_n (mem_we_n), .mem_be_n (mem_be_n), .mem_rdata (mem_rdata)
   );

   function automatic logic [15:0] pat(input logic [22:0] a);
      return a[15:0] ^ {a[22:16], 9'h0} ^ 16'h5A3C;
   endfunction

   // Device model: poison data until the required access time has elapsed.
   logic [22:0] prev_addr = '0;
   logic        prev_ce_n = 1'b1;
   int          age = 0;
   bit          full = 1'b1;
   always @(posedge clk) begin
      prev_addr <= mem_addr;
      prev_ce_n <= mem_ce_n;
      if (mem_ce_n) begin
         age <= 0; full <= 1'b1;
      end else if (prev_ce_n) begin
         age <= 1; full <= 1'b1;
      end else if (mem_addr != prev_addr) begin
         age <= 1; full <= (mem_addr[22:2] != prev_addr[22:2]);
      end else if (age < 1000) begin
         age <= age + 1;
      end
   end
   assign mem_rdata = (!mem_ce_n && !mem_oe_n && (age + 1 >= (full ? FIRST : PAGE)))
                      ? pat(mem_addr) : POISON;

   // Deselect-gap monitor (R9).
   int hi_run = 100;
   int gap_viol = 0;
   always @(negedge clk) begin
      if (mem_ce_n) hi_run <= hi_run + 1;
      else begin
         if (hi_run != 0 && hi_run < 2) gap_viol <= gap_viol + 1;
         hi_run <= 0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "strobes idle", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
      chk(mem_be_n == 2'b11, "R1", "lanes idle", mem_be_n, 2'b11);
      chk(!rsp_valid && !req_err && req_ready, "R1", "handshake idle",
          {rsp_valid, req_err, req_ready}, 3'b001);
   endtask

   task automatic t_burst(input logic [22:0] a, input int n);
      int got = 0;
      int bad_sel = 0, bad_pg = 0, bad_rdy = 0, bad_we = 0;
      int last_n = 0;
      int sel_lo = 0;
      bit done = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_addr = a; req_words = 3'(n); req_valid = 1'b1;
      for (int t = 1; t < 80 && !done; t++) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (!mem_we_n) bad_we++;
         if (!mem_ce_n) begin
            sel_lo++;
            if (mem_addr[22:2] != a[22:2]) bad_pg++;
            if (req_ready) bad_rdy++;
         end
         if (got < n && !rsp_valid && t > 1 &&
             (mem_ce_n || mem_oe_n || mem_be_n != 2'b00)) bad_sel++;
         if (rsp_valid) begin
            int k = got;
            logic [1:0] off = 2'(a[1:0] + 2'(k));
            logic [22:0] wa = {a[22:2], off};
            int exp_t = (k == 0) ? FIRST + 1 : last_n + PAGE;
            chk(t == exp_t, (k == 0) ? "R4" : "R5", "word timing", t, exp_t);
            chk(rsp_data == pat(wa) && rsp_tag == off, "R6", "word data/tag",
                {rsp_tag, rsp_data}, {off, pat(wa)});
            chk(rsp_last == (k == n - 1), "R7", "last marker", rsp_last, (k == n - 1));
            last_n = t;
            got++;
         end
         if (got == n && req_ready) done = 1;
      end
      chk(got == n, "R7", "word count", got, n);
      chk(bad_sel == 0 && sel_lo > 0 && bad_we == 0, "R2", "strobes held during burst", bad_sel + bad_we, 0);
      chk(bad_pg == 0, "R3", "page bits steady", bad_pg, 0);
      chk(bad_rdy == 0, "R10", "ready low while selected", bad_rdy, 0);
   endtask

   task automatic t_reject(input logic [22:0] a, input int n);
      int seen_rsp = 0, seen_sel = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_addr = a; req_words = 3'(n); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_err == 1'b1, "R8", "error pulse", req_err, 1);
      @(negedge clk);
      chk(req_err == 1'b0, "R8", "error single cycle", req_err, 0);
      for (int t = 0; t < FIRST + 4; t++) begin
         if (rsp_valid) seen_rsp++;
         if (!mem_ce_n) seen_sel++;
         @(negedge clk);
      end
      chk(seen_rsp == 0 && seen_sel == 0 && req_ready, "R8", "no access on refusal",
          seen_rsp + seen_sel, 0);
   endtask

   bit timed_out = 0;

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            @(negedge clk) rst_n = 1'b1;
            t_reset();
            t_burst(23'h000000, 4);
            t_burst(23'h123455, 3);   // offset 1
            t_burst(23'h0ABCDE, 2);   // offset 2
            t_burst(23'h3FFFF7, 1);   // offset 3
            t_burst(23'h7FFFFC, 4);
            t_reject(23'h000103, 2);  // offset 3 + 2 crosses page
            t_reject(23'h000200, 0);  // zero words
            t_reject(23'h000300, 5);  // too many words
            t_reject(23'h000402, 3);  // offset 2 + 3 crosses page
            t_burst(23'h000402, 2);   // fits exactly at page end
            t_burst(23'h000400, 1);   // immediately following
            @(negedge clk);
            chk(gap_viol == 0, "R9", "deselect gap", gap_viol, 0);
         end
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      disable fork;
      if (timed_out) chk(0, "WATCHDOG", "run hung", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule